// File: doc/BRIEF.md
# Radio Control Register Target on a Two-Wire Bus

This block is the host-facing control port of a radio tuner chip. An external bus master uses a two-wire serial bus (SCL clock, SDA data, both open-drain) to read and write a sparse set of 8-bit registers. The block oversamples both lines on its own system clock, which must run at least 16 times faster than SCL. It finds start, stop and repeated-start conditions, decodes the device address byte, takes a register sub-address, and then stores one data byte or returns the contents of a register.

Some registers hold configuration that the block presents on a flat output bus. Others report live status from the tuner. Two registers also act as commands. Writing the high byte of the 16-bit target value pulses a command-start strobe, and the full target is presented alongside it. Any write to the identity register pulses an abort strobe. The strobes are single-cycle pulses with no handshake. Neither the serial bus nor the strobes have any back-pressure: a command start cannot be refused or delayed by the receiver.

Top module: `radio_i2c_regs`

## Requirements
- R1: Address byte C0h (write) and C1h (read) are acknowledged. Any other address byte is not acknowledged, and the block then ignores the bus until the next start condition.
- R2: In a write, the byte after the address is the sub-address and the next byte is stored into that register. Further data bytes in the same transfer are acknowledged but discarded.
- R3: In a read, the block returns the register selected by the last written sub-address. It does so after either a repeated start or a stop followed by a start. Data goes out MSB first, and SDA is released during the master's acknowledge bit.
- R4: The block changes its SDA drive only while filtered SCL is low. Its acknowledge is driven low from the 8th to the 9th SCL falling edge of a byte.
- R5: Sub-address 00h reads as 12h. A write of any value to 00h gives a one-cycle cmd_abort pulse.
- R6: A write to 1Fh gives a one-cycle cmd_start pulse. During that cycle, cmd_target equals {new 1Fh value, 1Eh value}.
- R7: Sub-addresses 02h, 10h and 11h return stat_radio, stat_pos_lo and stat_pos_hi. Writes to them change nothing.
- R8: Registers 0Bh, 0Dh, 0Eh, 0Fh, 19h, 1Ah, 1Bh, 1Dh, 1Eh and 1Fh read back the last value written. They appear on cfg_bus as bytes 0 to 9 in that order (byte k at bits 8k+7:8k). pwr_en is bit 0 of register 0Fh.
- R9: After reset, every read/write register is 00h, pwr_en is 0 (standby), sda_oe is 0, and no strobe is active.
- R10: Unmapped sub-addresses read as 00h, and writes to them are ignored.
- R11: A start or stop condition inside a data byte ends the transfer without any register write.
- R12: A pulse on SCL or SDA shorter than FILT_LEN system clocks has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed SCL line |
| sda_i | input | 1 | Sensed SDA line |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| stat_radio | input | 8 | Radio status, read at 02h |
| stat_pos_lo | input | 8 | Tune position low, read at 10h |
| stat_pos_hi | input | 8 | Tune position high and status, read at 11h |
| cfg_bus | output | 80 | Read/write register contents, 10 bytes |
| pwr_en | output | 1 | Radio power enable (0 = standby) |
| cmd_start | output | 1 | One-cycle command-start strobe |
| cmd_abort | output | 1 | One-cycle command-abort strobe |
| cmd_target | output | 16 | Target value {1Fh, 1Eh} |

## Verification
Each SDA response is due 2 + FILT_LEN + 1 system clocks after the SCL edge that causes it (two synchronizer stages, the filter run, one FSM register); the default is six clocks. The bench holds every SCL phase for ten clocks and samples the line only at mid-high, so it never sees a value in transit. A register write lands one clock after the FSM strobe, and the command strobes appear in that same cycle. A monitor counts the strobes and latches cmd_target at each pulse, and those counts are compared after the stop. Glitch, mid-byte stop and foreign-address cases are each confirmed by reading the register back through the bus afterwards.

// File: rtl/radio_i2c_pkg.sv
package radio_i2c_pkg;
  localparam int NUM_RW = 10;
  localparam logic [7:0] RW_ADDR [NUM_RW] = '{8'h0B, 8'h0D, 8'h0E, 8'h0F, 8'h19,
                                             8'h1A, 8'h1B, 8'h1D, 8'h1E, 8'h1F};
  localparam int IDX_PWR    = 3;
  localparam int IDX_TGT_LO = 8;
  localparam int IDX_TGT_HI = 9;
  localparam logic [7:0] SUB_ID     = 8'h00;
  localparam logic [7:0] ID_VALUE   = 8'h12;
  localparam logic [7:0] SUB_STAT   = 8'h02;
  localparam logic [7:0] SUB_POS_LO = 8'h10;
  localparam logic [7:0] SUB_POS_HI = 8'h11;
  localparam logic [7:0] SUB_TGT_HI = 8'h1F;
  localparam logic [6:0] DEV_ADDR   = 7'h60;

  typedef enum logic [2:0] {
    PH_IDLE, PH_DEV, PH_SUB, PH_WDATA, PH_EXTRA, PH_READ, PH_SKIP
  } phase_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      filt   <= 1'b1;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw};
      if (sync_q[1] == filt) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        filt  <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign start_ev = scl & scl_q & sda_q & ~sda;
  assign stop_ev  = scl & scl_q & ~sda_q & sda;
  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import radio_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_f,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic [7:0] sub_addr
);
  phase_t     phase_q, next_q;
  logic [3:0] bit_q;
  logic [7:0] shift_q;
  logic [7:0] tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      next_q   <= PH_IDLE;
      bit_q    <= '0;
      shift_q  <= '0;
      tx_q     <= '0;
      sub_addr <= '0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_ev) begin
        phase_q <= PH_DEV;
        bit_q   <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_ev) begin
        phase_q <= PH_IDLE;
        bit_q   <= '0;
        sda_oe  <= 1'b0;
      end else if (phase_q != PH_IDLE && phase_q != PH_SKIP) begin
        if (scl_rise) begin
          if (bit_q < 4'd9) bit_q <= bit_q + 4'd1;
          if (bit_q < 4'd8) shift_q <= {shift_q[6:0], sda_f};
        end else if (scl_fall) begin
          if (bit_q == 4'd8) begin
            case (phase_q)
              PH_DEV: begin
                if (shift_q == {DEV_ADDR, 1'b0}) begin
                  sda_oe <= 1'b1;
                  next_q <= PH_SUB;
                end else if (shift_q == {DEV_ADDR, 1'b1}) begin
                  sda_oe <= 1'b1;
                  next_q <= PH_READ;
                end else begin
                  next_q <= PH_SKIP;
                end
              end
              PH_SUB: begin
                sda_oe   <= 1'b1;
                sub_addr <= shift_q;
                next_q   <= PH_WDATA;
              end
              PH_WDATA: begin
                sda_oe  <= 1'b1;
                wr_en   <= 1'b1;
                wr_data <= shift_q;
                next_q  <= PH_EXTRA;
              end
              PH_EXTRA: begin
                sda_oe <= 1'b1;
                next_q <= PH_EXTRA;
              end
              default: begin
                sda_oe <= 1'b0;
                next_q <= PH_SKIP;
              end
            endcase
          end else if (bit_q == 4'd9) begin
            bit_q   <= '0;
            phase_q <= next_q;
            if (next_q == PH_READ) begin
              tx_q   <= rd_data;
              sda_oe <= ~rd_data[7];
            end else begin
              sda_oe <= 1'b0;
            end
          end else if (phase_q == PH_READ && bit_q != 4'd0) begin
            sda_oe <= ~tx_q[3'(4'd7 - bit_q)];
          end
        end
      end
    end
  end
endmodule

// File: rtl/radio_reg_bank.sv
module radio_reg_bank
  import radio_i2c_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [7:0]          wr_data,
  input  logic [7:0]          sub_addr,
  input  logic [7:0]          stat_radio,
  input  logic [7:0]          stat_pos_lo,
  input  logic [7:0]          stat_pos_hi,
  output logic [7:0]          rd_data,
  output logic [NUM_RW*8-1:0] cfg_flat,
  output logic                cmd_start,
  output logic                cmd_abort
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_flat  <= '0;
      cmd_start <= 1'b0;
      cmd_abort <= 1'b0;
    end else begin
      cmd_start <= wr_en && (sub_addr == SUB_TGT_HI);
      cmd_abort <= wr_en && (sub_addr == SUB_ID);
      for (int i = 0; i < NUM_RW; i++) begin
        if (wr_en && sub_addr == RW_ADDR[i]) cfg_flat[i*8 +: 8] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    case (sub_addr)
      SUB_ID:     rd_data = ID_VALUE;
      SUB_STAT:   rd_data = stat_radio;
      SUB_POS_LO: rd_data = stat_pos_lo;
      SUB_POS_HI: rd_data = stat_pos_hi;
      default: begin
        for (int i = 0; i < NUM_RW; i++) begin
          if (sub_addr == RW_ADDR[i]) rd_data = cfg_flat[i*8 +: 8];
        end
      end
    endcase
  end
endmodule

// File: rtl/radio_i2c_regs.sv
module radio_i2c_regs
  import radio_i2c_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [7:0]  stat_radio,
  input  logic [7:0]  stat_pos_lo,
  input  logic [7:0]  stat_pos_hi,
  output logic [79:0] cfg_bus,
  output logic        pwr_en,
  output logic        cmd_start,
  output logic        cmd_abort,
  output logic [15:0] cmd_target
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw_v, filt_v;
  logic scl_filt, sda_filt;
  logic start_ev, stop_ev, scl_rise, scl_fall;
  logic wr_en;
  logic [7:0] wr_data, sub_addr, rd_data;
  logic [NUM_RW*8-1:0] cfg_flat;

  assign raw_v = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_v[g]),
      .filt (filt_v[g])
    );
  end

  assign scl_filt = filt_v[0];
  assign sda_filt = filt_v[1];

  i2c_cond_detect u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl     (scl_filt),
    .sda     (sda_filt),
    .start_ev(start_ev),
    .stop_ev (stop_ev),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall)
  );

  i2c_byte_engine u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_ev(start_ev),
    .stop_ev (stop_ev),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .sda_f   (sda_filt),
    .rd_data (rd_data),
    .sda_oe  (sda_oe),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .sub_addr(sub_addr)
  );

  radio_reg_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .sub_addr   (sub_addr),
    .stat_radio (stat_radio),
    .stat_pos_lo(stat_pos_lo),
    .stat_pos_hi(stat_pos_hi),
    .rd_data    (rd_data),
    .cfg_flat   (cfg_flat),
    .cmd_start  (cmd_start),
    .cmd_abort  (cmd_abort)
  );

  assign cfg_bus    = cfg_flat;
  assign pwr_en     = cfg_flat[IDX_PWR*8];
  assign cmd_target = {cfg_flat[IDX_TGT_HI*8 +: 8], cfg_flat[IDX_TGT_LO*8 +: 8]};
endmodule

// File: rtl/radio_i2c_regs_chk.sv
module radio_i2c_regs_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic sda_oe,
  input logic cmd_start,
  input logic cmd_abort
);
  // R4: SDA drive is steady across any cycle where filtered SCL stays high
  assert_sda_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_oe));

  // R6: command start strobe lasts one cycle
  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start);

  // R5: abort strobe lasts one cycle
  assert_abort_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |=> !cmd_abort);

  // R5/R6: the two strobes come from different writes
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_start && cmd_abort));
endmodule

bind radio_i2c_regs radio_i2c_regs_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_f    (scl_filt),
  .sda_oe   (sda_oe),
  .cmd_start(cmd_start),
  .cmd_abort(cmd_abort)
);

// File: tb/radio_i2c_regs_tb_top.sv
module radio_i2c_regs_tb_top;
  localparam int Q = 10;
  localparam int NVEC = 13;
  // {sub, write value, expected read}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h0B_A5_A5, 24'h0D_3C_3C, 24'h0E_81_81, 24'h0F_FE_FE, 24'h19_5A_5A,
    24'h1A_FF_FF, 24'h1B_01_01, 24'h1D_C3_C3, 24'h1E_34_34, 24'h02_77_4D,
    24'h10_66_9E, 24'h05_AA_00, 24'h00_99_12
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, pwr_en, cmd_start, cmd_abort;
  logic [79:0] cfg_bus;
  logic [15:0] cmd_target;
  logic sda_line;
  int n_tests = 0, n_fail = 0, n_start = 0, n_abort = 0;
  logic [15:0] last_tgt = '0;
  logic glitch_en = 1'b0;

  always #10 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  radio_i2c_regs dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .stat_radio(8'h4D), .stat_pos_lo(8'h9E), .stat_pos_hi(8'h2B),
    .cfg_bus(cfg_bus), .pwr_en(pwr_en), .cmd_start(cmd_start),
    .cmd_abort(cmd_abort), .cmd_target(cmd_target)
  );

  always @(posedge clk) begin
    if (cmd_start) begin n_start <= n_start + 1; last_tgt <= cmd_target; end
    if (cmd_abort) n_abort <= n_abort + 1;
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b, input logic gl_scl, input logic gl_sda);
    m_sda = b; wq(); m_scl = 1'b1; wq();
    if (gl_sda) begin m_sda = ~b; repeat (2) @(posedge clk); #1; m_sda = b; end
    wq(); m_scl = 1'b0;
    if (gl_scl) begin repeat (3) @(posedge clk); #1; m_scl = 1'b1;
      repeat (2) @(posedge clk); #1; m_scl = 1'b0; end
    wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--)
      send_bit(b[i], glitch_en && i == 4, glitch_en && i == 2);
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); ack = ~sda_line; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); m_scl = 1'b1; wq(); d[i] = sda_line; wq(); m_scl = 1'b0; wq();
    end
    m_sda = nack; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq(); m_sda = 1'b1;
  endtask

  task automatic write_reg(input logic [7:0] sub, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start(); send_byte(8'hC0, a0); send_byte(sub, a1); send_byte(d, a2); bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic read_reg(input logic [7:0] sub, input logic via_stop,
                          output logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start(); send_byte(8'hC0, a0); send_byte(sub, a1);
    if (via_stop) bus_stop();
    bus_start(); send_byte(8'hC1, a2); recv_byte(1'b1, d); bus_stop();
    ok = a0 & a1 & a2;
  endtask

  function automatic string tag_of(input logic [7:0] sub);
    if (sub == 8'h00) return "R5";
    if (sub == 8'h02 || sub == 8'h10 || sub == 8'h11) return "R7";
    if (sub == 8'h05) return "R10";
    return "R8";
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic ok, ack, a;
    logic [7:0] d;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    wq();
    // R9: reset state at the ports
    check(sda_oe == 1'b0 && pwr_en == 1'b0, "R9 sda_oe/pwr_en", {sda_oe, pwr_en}, 0);
    check(cfg_bus == '0, "R9 cfg_bus", cfg_bus[31:0], 0);
    read_reg(8'h0F, 1'b0, d, ok);
    check(ok && d == 8'h00, "R9 reg0F", d, 0);

    // R1 R2 R3 R8 R7 R10 R5: table of write-then-read
    for (int v = 0; v < NVEC; v++) begin
      write_reg(VEC[v][23:16], VEC[v][15:8], ok);
      check(ok, "R1 write acks", ok, 1);
      read_reg(VEC[v][23:16], 1'b0, d, ok);
      check(ok && d == VEC[v][7:0], tag_of(VEC[v][23:16]), d, VEC[v][7:0]);
    end
    check(cfg_bus[7:0] == 8'hA5 && cfg_bus[71:64] == 8'h34, "R8 cfg_bus bytes",
          {cfg_bus[71:64], cfg_bus[7:0]}, 16'h34A5);
    check(n_abort == 1, "R5 abort count", n_abort, 1);

    // R8: power enable bit
    write_reg(8'h0F, 8'h01, ok);
    check(pwr_en == 1'b1, "R8 pwr_en", pwr_en, 1);

    // R6: command start with target
    write_reg(8'h1F, 8'h12, ok);
    check(n_start == 1 && last_tgt == 16'h1234, "R6 cmd start/target", last_tgt, 16'h1234);

    // R2: burst, only first byte stored; extras acked
    bus_start(); send_byte(8'hC0, a); send_byte(8'h0B, a); send_byte(8'hA1, a);
    send_byte(8'hB2, ack); send_byte(8'hC3, a); bus_stop();
    check(ack, "R2 extra byte ack", ack, 1);
    read_reg(8'h0B, 1'b1, d, ok);
    check(d == 8'hA1, "R2 burst first byte kept", d, 8'hA1);
    check(ok, "R3 stop-then-start read", ok, 1);

    // R1: foreign address not acked, rest ignored
    bus_start(); send_byte(8'hA0, ack); send_byte(8'h0B, a); send_byte(8'h55, a); bus_stop();
    check(!ack, "R1 foreign address nack", ack, 0);
    read_reg(8'h0B, 1'b0, d, ok);
    check(d == 8'hA1, "R1 foreign write ignored", d, 8'hA1);

    // R11: stop inside data byte
    bus_start(); send_byte(8'hC0, a); send_byte(8'h0D, a);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0, 1'b0);
    bus_stop();
    read_reg(8'h0D, 1'b0, d, ok);
    check(d == 8'h3C, "R11 mid-byte stop", d, 8'h3C);

    // R12: short glitches on SCL and SDA during a write
    bus_start(); send_byte(8'hC0, a); send_byte(8'h19, a);
    glitch_en = 1'b1; send_byte(8'h6B, ack); glitch_en = 1'b0; bus_stop();
    read_reg(8'h19, 1'b0, d, ok);
    check(d == 8'h6B && ack, "R12 glitch rejected", d, 8'h6B);

    // R7: high status register
    read_reg(8'h11, 1'b0, d, ok);
    check(d == 8'h2B, "R7 reg11", d, 8'h2B);
    check(n_start == 1 && n_abort == 1, "R6 no stray strobes", n_start, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule